// File: doc/BRIEF.md
# Four-Level LCD Drive Selector

This block sits between the scan logic of a dot-matrix LCD driver and the analog output switches. On every scan clock it takes the index of the row being driven, the on/off pattern for that row across all segment columns, and the frame polarity flag. From these it produces a 2-bit level code for every common and every segment pin. Each code picks one of four bias rails, and external switches route that rail to the pin. Between the two frame types, the select and non-select choices move to the mirror rail so that each pixel sees no net DC.

Commons and segments use different non-select rail pairs. The highest rail is VDSP, then V1, V2, V3 and V4, and the lowest is GND. A common that is not selected sits on V1 or V4. A segment that is off sits on V2 or V3. Two overrides act on the outputs. Blanking sends every segment to its non-select level while the commons keep scanning. Static reset parks every pin on its low bias rail, whatever the other inputs are. All outputs are registered.

Top module: `lcd_level_sel`

## Requirements
- R1: The level codes are 00 = GND, 01 = low bias rail and 11 = VDSP. The code 10 means the high bias rail. For commons the low bias rail is V4 and the high bias rail is V1. For segments the low bias rail is V3 and the high bias rail is V2. Common i occupies bits [2i+1:2i] of `comCodes`. Segment i occupies bits [2i+1:2i] of `segCodes`.
- R2: Outside static reset, exactly one common is at a select level (00 or 11). That common is the one whose index equals `rowIdx`.
- R3: With `polarity` = 0 (frame A), the selected common is 11 and every other common is 01.
- R4: With `polarity` = 1 (frame B), the selected common is 00 and every other common is 10.
- R5: In frame A without blanking, a segment whose data bit is 1 is 00 and a segment whose data bit is 0 is 10.
- R6: In frame B without blanking, a segment whose data bit is 1 is 11 and a segment whose data bit is 0 is 01.
- R7: Bit i of `segData` controls segment i only.
- R8: While `blank` = 1 and static reset is off, every segment takes the non-select code of the current frame (10 in frame A, 01 in frame B), whatever the data. The commons keep scanning as in R2 to R4.
- R9: While `staticReset` = 1, every common and every segment is 01, regardless of `blank`, `polarity`, `rowIdx` and `segData`.
- R10: Outputs change only on the rising clock edge and reflect the inputs sampled at that edge. An asynchronous low on `rstN` forces every output to 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rstN | input | 1 | Asynchronous active-low register reset |
| staticReset | input | 1 | Forces the static light-out state |
| blank | input | 1 | Forces all segments to non-select |
| polarity | input | 1 | Frame type: 0 = frame A, 1 = frame B |
| rowIdx | input | ROW_W (3) | Index of the row being driven |
| segData | input | NUM_SEG (64) | Row pixel data, 1 = on |
| comCodes | output | 2*NUM_COM (16) | Packed common level codes |
| segCodes | output | 2*NUM_SEG (128) | Packed segment level codes |

## Verification
Every row index is driven in both polarities so that the position of the select code and its rail can be checked on their own. All-ones, all-zeros and walking-one segment patterns separate on/off rail selection from the bit-to-pin mapping. Blanking and static reset are applied together with non-trivial data and both polarities, which shows which override wins and that the commons keep scanning under blanking. Random mixes of all inputs then catch interactions, and a sample taken between clock edges checks that outputs move only at the edge.

// File: rtl/lcdsel_pkg.sv
package lcdsel_pkg;

  typedef logic [1:0] lvl_t;

  localparam lvl_t LVL_GND  = 2'b00;
  localparam lvl_t LVL_LOW  = 2'b01;
  localparam lvl_t LVL_HIGH = 2'b10;
  localparam lvl_t LVL_VDSP = 2'b11;

  // Strobes from control to datapath: the four rail choices for this cycle
  typedef struct packed {
    lvl_t comSelLvl;
    lvl_t comIdleLvl;
    lvl_t segOnLvl;
    lvl_t segOffLvl;
  } drvCtrl_t;

endpackage

// File: rtl/lcdsel_ctrl.sv
module lcdsel_ctrl
  import lcdsel_pkg::*;
#(
  parameter int NUM_COM = 8,
  localparam int ROW_W = (NUM_COM > 1) ? $clog2(NUM_COM) : 1
) (
  input  logic               staticReset,
  input  logic               blank,
  input  logic               polarity,
  input  logic [ROW_W-1:0]   rowIdx,
  output drvCtrl_t           ctrl,
  output logic [NUM_COM-1:0] rowSel
);

  // Rail choice per pin class: static reset wins over blanking
  always_comb begin
    if (staticReset) begin
      ctrl.comSelLvl  = LVL_LOW;
      ctrl.comIdleLvl = LVL_LOW;
      ctrl.segOnLvl   = LVL_LOW;
      ctrl.segOffLvl  = LVL_LOW;
    end else begin
      ctrl.comSelLvl  = polarity ? LVL_GND  : LVL_VDSP;
      ctrl.comIdleLvl = polarity ? LVL_HIGH : LVL_LOW;
      ctrl.segOffLvl  = polarity ? LVL_LOW  : LVL_HIGH;
      if (blank) ctrl.segOnLvl = polarity ? LVL_LOW : LVL_HIGH;
      else       ctrl.segOnLvl = polarity ? LVL_VDSP : LVL_GND;
    end
  end

  // Row decode to a one-hot select
  always_comb begin
    for (int i = 0; i < NUM_COM; i++) begin
      rowSel[i] = (rowIdx == ROW_W'(i));
    end
  end

endmodule

// File: rtl/lcdsel_datapath.sv
module lcdsel_datapath
  import lcdsel_pkg::*;
#(
  parameter int NUM_COM = 8,
  parameter int NUM_SEG = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  drvCtrl_t             ctrl,
  input  logic [NUM_COM-1:0]   rowSel,
  input  logic [NUM_SEG-1:0]   segData,
  output logic [2*NUM_COM-1:0] comCodes,
  output logic [2*NUM_SEG-1:0] segCodes
);

  genvar gi;

  generate
    for (gi = 0; gi < NUM_COM; gi++) begin : g_com
      lvl_t nextLvl;
      assign nextLvl = rowSel[gi] ? ctrl.comSelLvl : ctrl.comIdleLvl;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) comCodes[2*gi +: 2] <= LVL_LOW;
        else       comCodes[2*gi +: 2] <= nextLvl;
      end
    end

    for (gi = 0; gi < NUM_SEG; gi++) begin : g_seg
      lvl_t nextLvl;
      assign nextLvl = segData[gi] ? ctrl.segOnLvl : ctrl.segOffLvl;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) segCodes[2*gi +: 2] <= LVL_LOW;
        else       segCodes[2*gi +: 2] <= nextLvl;
      end
    end
  endgenerate

endmodule

// File: rtl/lcd_level_sel.sv
module lcd_level_sel
  import lcdsel_pkg::*;
#(
  parameter int NUM_COM = 8,
  parameter int NUM_SEG = 64,
  localparam int ROW_W = (NUM_COM > 1) ? $clog2(NUM_COM) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 staticReset,
  input  logic                 blank,
  input  logic                 polarity,
  input  logic [ROW_W-1:0]     rowIdx,
  input  logic [NUM_SEG-1:0]   segData,
  output logic [2*NUM_COM-1:0] comCodes,
  output logic [2*NUM_SEG-1:0] segCodes
);

  drvCtrl_t           ctrl;
  logic [NUM_COM-1:0] rowSel;

  lcdsel_ctrl #(.NUM_COM(NUM_COM)) u_ctrl (
    .staticReset(staticReset),
    .blank      (blank),
    .polarity   (polarity),
    .rowIdx     (rowIdx),
    .ctrl       (ctrl),
    .rowSel     (rowSel)
  );

  lcdsel_datapath #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .rowSel  (rowSel),
    .segData (segData),
    .comCodes(comCodes),
    .segCodes(segCodes)
  );

  // Observation vectors taken from the output codes
  logic [NUM_COM-1:0] comIsSel, comLsb;
  logic [NUM_SEG-1:0] segIsSel, segLsb;
  always_comb begin
    for (int i = 0; i < NUM_COM; i++) begin
      comIsSel[i] = (comCodes[2*i+1] == comCodes[2*i]);
      comLsb[i]   = comCodes[2*i];
    end
    for (int i = 0; i < NUM_SEG; i++) begin
      segIsSel[i] = (segCodes[2*i+1] == segCodes[2*i]);
      segLsb[i]   = segCodes[2*i];
    end
  end

  AST_STATIC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    staticReset |=> (comCodes == {NUM_COM{LVL_LOW}} && segCodes == {NUM_SEG{LVL_LOW}})); // R9

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    !staticReset |=> ($countones(comIsSel) == 1 && comIsSel[$past(rowIdx)])); // R2

  AST_FRAME_A_RAILS: assert property (@(posedge clk) disable iff (!rstN)
    (!staticReset && !polarity) |=> (&comLsb && !(|segLsb))); // R3

  AST_FRAME_B_RAILS: assert property (@(posedge clk) disable iff (!rstN)
    (!staticReset && polarity) |=> (!(|comLsb) && &segLsb)); // R4

  AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rstN)
    (!staticReset && blank) |=> (segIsSel == '0)); // R8

  AST_DATA_MAP: assert property (@(posedge clk) disable iff (!rstN)
    (!staticReset && !blank) |=> (segIsSel == $past(segData))); // R7

endmodule

// File: tb/lcd_level_sel_bench.sv
module lcd_level_sel_bench;

  localparam int NC = 8;
  localparam int NS = 64;
  localparam int RW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          staticReset = 1'b0;
  logic          blank = 1'b0;
  logic          polarity = 1'b0;
  logic [RW-1:0] rowIdx = '0;
  logic [NS-1:0] segData = '0;
  logic [2*NC-1:0] comCodes;
  logic [2*NS-1:0] segCodes;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  lcd_level_sel u_lcd_level_sel (
    .clk(clk), .rstN(rstN), .staticReset(staticReset), .blank(blank),
    .polarity(polarity), .rowIdx(rowIdx), .segData(segData),
    .comCodes(comCodes), .segCodes(segCodes)
  );

  function automatic logic [2*NC-1:0] expCom(logic [RW-1:0] row, logic pol, logic sr);
    logic [2*NC-1:0] v;
    for (int i = 0; i < NC; i++) begin
      if (sr)               v[2*i +: 2] = 2'b01;
      else if (i == row)    v[2*i +: 2] = pol ? 2'b00 : 2'b11;
      else                  v[2*i +: 2] = pol ? 2'b10 : 2'b01;
    end
    return v;
  endfunction

  function automatic logic [2*NS-1:0] expSeg(logic [NS-1:0] d, logic pol, logic sr, logic bl);
    logic [2*NS-1:0] v;
    for (int i = 0; i < NS; i++) begin
      if (sr)                v[2*i +: 2] = 2'b01;
      else if (bl || !d[i])  v[2*i +: 2] = pol ? 2'b01 : 2'b10;
      else                   v[2*i +: 2] = pol ? 2'b11 : 2'b00;
    end
    return v;
  endfunction

  task automatic checkOut(string tag, logic [2*NC-1:0] eCom, logic [2*NS-1:0] eSeg);
    checks++;
    if (comCodes !== eCom) begin
      failures++;
      $display("FAIL %s commons actual=%h expected=%h", tag, comCodes, eCom);
    end
    checks++;
    if (segCodes !== eSeg) begin
      failures++;
      $display("FAIL %s segments actual=%h expected=%h", tag, segCodes, eSeg);
    end
  endtask

  // Drive at the falling edge, sample just after the next rising edge
  task automatic apply(string tag, logic [RW-1:0] row, logic [NS-1:0] d,
                       logic pol, logic sr, logic bl);
    @(negedge clk);
    rowIdx = row; segData = d; polarity = pol; staticReset = sr; blank = bl;
    @(posedge clk);
    #1;
    checkOut(tag, expCom(row, pol, sr), expSeg(d, pol, sr, bl));
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5EED_1234);

    // R10: asynchronous reset state
    #3;
    checkOut("R10 async reset", {NC{2'b01}}, {NS{2'b01}});
    @(negedge clk);
    rstN = 1'b1;

    // R3 R5 frame A basic patterns
    apply("R3 R5 frameA ones", 3'd0, {NS{1'b1}}, 1'b0, 1'b0, 1'b0);
    apply("R5 frameA zeros",   3'd5, {NS{1'b0}}, 1'b0, 1'b0, 1'b0);
    // R4 R6 frame B basic patterns
    apply("R4 R6 frameB ones", 3'd7, {NS{1'b1}}, 1'b1, 1'b0, 1'b0);
    apply("R6 frameB zeros",   3'd2, {NS{1'b0}}, 1'b1, 1'b0, 1'b0);

    // R2 every row, both polarities
    for (int p = 0; p < 2; p++)
      for (int r = 0; r < NC; r++)
        apply("R2 row scan", RW'(r), 64'hA5A5_0F0F_3C3C_FFFF, p[0], 1'b0, 1'b0);

    // R7 walking one across several positions
    for (int k = 0; k < NS; k += 7)
      apply("R7 walking one", 3'd1, 64'd1 << k, k[0], 1'b0, 1'b0);
    apply("R7 top bit", 3'd6, 64'h8000_0000_0000_0000, 1'b0, 1'b0, 1'b0);

    // R8 blanking, both frames, commons still scanning
    apply("R8 blank frameA", 3'd4, {NS{1'b1}}, 1'b0, 1'b0, 1'b1);
    apply("R8 blank frameB", 3'd3, 64'hDEAD_BEEF_0123_4567, 1'b1, 1'b0, 1'b1);

    // R9 static reset wins over blank and polarity
    apply("R9 static reset",       3'd7, {NS{1'b1}}, 1'b1, 1'b1, 1'b0);
    apply("R9 static reset blank", 3'd0, 64'h1234_5678_9ABC_DEF0, 1'b0, 1'b1, 1'b1);

    // R10 outputs hold between edges
    apply("R10 pre", 3'd2, 64'hFFFF_0000_FFFF_0000, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    polarity = 1'b1; rowIdx = 3'd5;
    #1;
    checkOut("R10 hold between edges", expCom(3'd2, 1'b0, 1'b0),
             expSeg(64'hFFFF_0000_FFFF_0000, 1'b0, 1'b0, 1'b0));
    @(posedge clk);
    #1;
    checkOut("R10 update at edge", expCom(3'd5, 1'b1, 1'b0),
             expSeg(64'hFFFF_0000_FFFF_0000, 1'b1, 1'b0, 1'b0));

    // R1 mixed random stimulus
    for (int n = 0; n < 300; n++) begin
      logic [NS-1:0] d;
      logic sr, bl;
      d  = {$urandom(), $urandom()};
      sr = ($urandom() % 8) == 0;
      bl = ($urandom() % 4) == 0;
      apply("R1 random", RW'($urandom()), d, 1'($urandom()), sr, bl);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule